// File: doc/BRIEF.md
# Hardwired Instruction Control Sequencer

This block is the control unit of a small accumulator CPU. It steps through a fixed sequence of states, one state per clock cycle. Two states fetch an instruction: the first places the program counter on the address path, and the second reads the instruction word. A decode state then picks an execute path from the opcode. Each execute state drives a fixed set of datapath enables. The registers, the ALU and the memory sit outside the block and only receive its strobes.

There are seven states. `ST_FETCH_ADDR` always goes to `ST_FETCH_WORD`. `ST_FETCH_WORD` stays where it is until memory reports ready, then goes to `ST_DECODE`. `ST_DECODE` goes to `ST_EXEC_ADD` for opcode 000, to `ST_EXEC_LOAD` for 001 and to `ST_BRZ_TEST` for 010. Every other opcode goes back to `ST_FETCH_ADDR`. `ST_BRZ_TEST` goes to `ST_BRANCH_TAKE` when the zero flag is 1, and otherwise back to `ST_FETCH_ADDR`. `ST_EXEC_ADD`, `ST_EXEC_LOAD` and `ST_BRANCH_TAKE` all return to `ST_FETCH_ADDR`. All transitions happen on the rising clock edge.

The strobes are decoded from the current state alone, with two exceptions. In `ST_FETCH_WORD` the memory-ready input gates the IR load and PC increment strobes. While reset is high, every strobe is forced low.

Top module: `ctl_seq`

## Requirements
- R1: While `rst` is high, all eight strobes are 0. In the first cycle after `rst` falls, the block is in `ST_FETCH_ADDR`.
- R2: `ST_FETCH_ADDR` drives exactly `pc_oe` and `mar_ld`. The next cycle is always `ST_FETCH_WORD`.
- R3: In `ST_FETCH_WORD`, while `mem_rdy` is 0, only `mem_rd` is driven and the block stays in `ST_FETCH_WORD`.
- R4: In `ST_FETCH_WORD`, when `mem_rdy` is 1, exactly `mem_rd`, `ir_ld` and `pc_inc` are driven in that same cycle. The next cycle is `ST_DECODE`, which drives no strobe.
- R5: In `ST_DECODE`, opcode 000 leads to `ST_EXEC_ADD`. That state drives exactly `alu_add` and `acc_ld`, then returns to `ST_FETCH_ADDR`.
- R6: In `ST_DECODE`, opcode 001 leads to `ST_EXEC_LOAD`. That state drives exactly `mem_rd` and `acc_ld`, then returns to `ST_FETCH_ADDR`.
- R7: In `ST_DECODE`, opcode 010 leads to `ST_BRZ_TEST`, which drives no strobe. If `zero_flag` is 1 in that cycle, the next state is `ST_BRANCH_TAKE`, which drives exactly `pc_ld` and then returns to `ST_FETCH_ADDR`. If `zero_flag` is 0, the next state is `ST_FETCH_ADDR`.
- R8: In `ST_DECODE`, opcodes 011 through 111 lead straight back to `ST_FETCH_ADDR`.
- R9: `opcode` has no effect outside `ST_DECODE`, and `zero_flag` has no effect outside `ST_BRZ_TEST`.
- R10: When `rst` and `mem_rdy` are both high in `ST_FETCH_WORD`, reset wins. No strobe is driven, and the block is in `ST_FETCH_ADDR` once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W (3) | Opcode field of the instruction register |
| zero_flag | input | 1 | Zero status flag from the ALU |
| mem_rdy | input | 1 | Memory data valid for the current read |
| pc_oe | output | 1 | Drive the program counter onto the address path |
| mar_ld | output | 1 | Load the memory address register |
| mem_rd | output | 1 | Memory read request |
| ir_ld | output | 1 | Load the instruction register |
| pc_inc | output | 1 | Increment the program counter |
| alu_add | output | 1 | Select addition in the ALU |
| acc_ld | output | 1 | Load the accumulator |
| pc_ld | output | 1 | Load the program counter from the instruction address field |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the arrival of memory-ready and the word-fetch state's own read strobe. The IR load and PC increment must appear in that same cycle, with no delay, and the state must move on at the following edge. The bench holds memory-ready low for zero, one and several cycles to cover this.

The second pair is reset and memory-ready, which the bench raises together in the middle of a word fetch. A behavioural model of the fetch, decode and execute sequence predicts the full strobe vector in every cycle. The bench compares that prediction with the outputs every clock. During this collision the model must show reset winning: no strobe driven and a clean restart.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR  = 3'd0,
        ST_FETCH_WORD  = 3'd1,
        ST_DECODE      = 3'd2,
        ST_EXEC_ADD    = 3'd3,
        ST_EXEC_LOAD   = 3'd4,
        ST_BRZ_TEST    = 3'd5,
        ST_BRANCH_TAKE = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic pc_oe;
        logic mar_ld;
        logic mem_rd;
        logic ir_ld;
        logic pc_inc;
        logic alu_add;
        logic acc_ld;
        logic pc_ld;
    } strobe_t;

    localparam int STROBE_N = $bits(strobe_t);

endpackage

// File: rtl/ctl_seq_next.sv
module ctl_seq_next
    import ctl_seq_pkg::*;
#(
    parameter int              OP_W     = 3,
    parameter logic [OP_W-1:0] OPC_ADD  = 3'b000,
    parameter logic [OP_W-1:0] OPC_LOAD = 3'b001,
    parameter logic [OP_W-1:0] OPC_BRZ  = 3'b010
) (
    input  seq_state_e      state_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            zero_i,
    input  logic            rdy_i,
    output seq_state_e      next_o
);

    // Opcode dispatch used only by the decode state
    seq_state_e dispatch;

    always_comb begin
        if (opcode_i == OPC_ADD) begin
            dispatch = ST_EXEC_ADD;
        end else if (opcode_i == OPC_LOAD) begin
            dispatch = ST_EXEC_LOAD;
        end else if (opcode_i == OPC_BRZ) begin
            dispatch = ST_BRZ_TEST;
        end else begin
            dispatch = ST_FETCH_ADDR;   // unused codes behave as no-op
        end
    end

    always_comb begin
        unique case (state_i)
            ST_FETCH_ADDR:  next_o = ST_FETCH_WORD;
            ST_FETCH_WORD:  next_o = rdy_i ? ST_DECODE : ST_FETCH_WORD;
            ST_DECODE:      next_o = dispatch;
            ST_EXEC_ADD:    next_o = ST_FETCH_ADDR;
            ST_EXEC_LOAD:   next_o = ST_FETCH_ADDR;
            ST_BRZ_TEST:    next_o = zero_i ? ST_BRANCH_TAKE : ST_FETCH_ADDR;
            ST_BRANCH_TAKE: next_o = ST_FETCH_ADDR;
            default:        next_o = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/ctl_seq_outdec.sv
module ctl_seq_outdec
    import ctl_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       rst_i,
    input  logic       rdy_i,
    output strobe_t    strobe_o
);

    strobe_t raw;

    always_comb begin
        raw = '0;
        unique case (state_i)
            ST_FETCH_ADDR: begin
                raw.pc_oe  = 1'b1;
                raw.mar_ld = 1'b1;
            end
            ST_FETCH_WORD: begin
                raw.mem_rd = 1'b1;
                raw.ir_ld  = rdy_i;   // capture the word in the ready cycle
                raw.pc_inc = rdy_i;
            end
            ST_DECODE: begin
                raw = '0;
            end
            ST_EXEC_ADD: begin
                raw.alu_add = 1'b1;
                raw.acc_ld  = 1'b1;
            end
            ST_EXEC_LOAD: begin
                raw.mem_rd = 1'b1;
                raw.acc_ld = 1'b1;
            end
            ST_BRZ_TEST: begin
                raw = '0;
            end
            ST_BRANCH_TAKE: begin
                raw.pc_ld = 1'b1;
            end
            default: begin
                raw = '0;
            end
        endcase
    end

    // Reset holds every strobe quiet
    assign strobe_o = rst_i ? strobe_t'('0) : raw;

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_seq_pkg::*;
#(
    parameter int              OP_W     = 3,
    parameter logic [OP_W-1:0] OPC_ADD  = 3'b000,
    parameter logic [OP_W-1:0] OPC_LOAD = 3'b001,
    parameter logic [OP_W-1:0] OPC_BRZ  = 3'b010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            zero_flag,
    input  logic            mem_rdy,
    output logic            pc_oe,
    output logic            mar_ld,
    output logic            mem_rd,
    output logic            ir_ld,
    output logic            pc_inc,
    output logic            alu_add,
    output logic            acc_ld,
    output logic            pc_ld
);

    seq_state_e state_q;
    seq_state_e state_d;
    strobe_t    strobe;

    ctl_seq_next #(
        .OP_W     (OP_W),
        .OPC_ADD  (OPC_ADD),
        .OPC_LOAD (OPC_LOAD),
        .OPC_BRZ  (OPC_BRZ)
    ) u_next (
        .state_i  (state_q),
        .opcode_i (opcode),
        .zero_i   (zero_flag),
        .rdy_i    (mem_rdy),
        .next_o   (state_d)
    );

    ctl_seq_outdec u_outdec (
        .state_i  (state_q),
        .rst_i    (rst),
        .rdy_i    (mem_rdy),
        .strobe_o (strobe)
    );

    // The only sequential element: the state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_oe   = strobe.pc_oe;
    assign mar_ld  = strobe.mar_ld;
    assign mem_rd  = strobe.mem_rd;
    assign ir_ld   = strobe.ir_ld;
    assign pc_inc  = strobe.pc_inc;
    assign alu_add = strobe.alu_add;
    assign acc_ld  = strobe.acc_ld;
    assign pc_ld   = strobe.pc_ld;

endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk (
    input logic clk,
    input logic rst,
    input logic mem_rdy,
    input logic pc_oe,
    input logic mar_ld,
    input logic mem_rd,
    input logic ir_ld,
    input logic pc_inc,
    input logic alu_add,
    input logic acc_ld,
    input logic pc_ld
);

    logic [7:0] strobes;
    assign strobes = {pc_oe, mar_ld, mem_rd, ir_ld, pc_inc, alu_add, acc_ld, pc_ld};

    // R1 and R10: reset silences every strobe
    always @(negedge clk) begin
        if (rst === 1'b1) begin
            assert_reset_quiet_R1: assert (strobes == 8'h00);
        end
    end

    // R2: address phase is followed by the word fetch
    assert_addr_to_word_R2: assert property (@(posedge clk) disable iff (rst)
        pc_oe |=> (mem_rd && !acc_ld));

    // R2: address phase drives its pair and nothing else
    assert_addr_pair_R2: assert property (@(posedge clk) disable iff (rst)
        pc_oe |-> ($countones(strobes) == 2 && mar_ld));

    // R3: waiting fetch holds and loads nothing
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !acc_ld && !mem_rdy) |-> (!ir_ld && !pc_inc));

    assert_wait_stay_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !acc_ld && !mem_rdy) |=> mem_rd);

    // R4: capture happens only with ready and is followed by a quiet decode
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        ir_ld |-> (pc_inc && mem_rd && mem_rdy));

    assert_decode_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (strobes == 8'h00));

    // R5: add step always loads the accumulator
    assert_add_pair_R5: assert property (@(posedge clk) disable iff (rst)
        alu_add |-> (acc_ld && $countones(strobes) == 2));

    // R5 and R6: every execute step returns to the address phase
    assert_exec_return_R6: assert property (@(posedge clk) disable iff (rst)
        acc_ld |=> (pc_oe && mar_ld));

    // R7: branch take returns to the address phase
    assert_take_return_R7: assert property (@(posedge clk) disable iff (rst)
        pc_ld |=> (pc_oe && mar_ld));

endmodule

bind ctl_seq ctl_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rdy (mem_rdy),
    .pc_oe   (pc_oe),
    .mar_ld  (mar_ld),
    .mem_rd  (mem_rd),
    .ir_ld   (ir_ld),
    .pc_inc  (pc_inc),
    .alu_add (alu_add),
    .acc_ld  (acc_ld),
    .pc_ld   (pc_ld)
);

// File: tb/ctl_seq_tb_top.sv
`timescale 1ns/1ps
module ctl_seq_tb_top;

    // Model phases (bench-local numbering)
    localparam int PH_ADDR = 0;
    localparam int PH_WORD = 1;
    localparam int PH_DEC  = 2;
    localparam int PH_ADD  = 3;
    localparam int PH_LOAD = 4;
    localparam int PH_BRZ  = 5;
    localparam int PH_TAKE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opcode = 3'b000;
    logic       zero_flag = 1'b0;
    logic       mem_rdy = 1'b0;
    logic       pc_oe, mar_ld, mem_rd, ir_ld, pc_inc, alu_add, acc_ld, pc_ld;

    int checks = 0;
    int failures = 0;
    int ph = PH_ADDR;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ctl_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .zero_flag (zero_flag),
        .mem_rdy   (mem_rdy),
        .pc_oe     (pc_oe),
        .mar_ld    (mar_ld),
        .mem_rd    (mem_rd),
        .ir_ld     (ir_ld),
        .pc_inc    (pc_inc),
        .alu_add   (alu_add),
        .acc_ld    (acc_ld),
        .pc_ld     (pc_ld)
    );

    // Expected strobe vector {pc_oe,mar_ld,mem_rd,ir_ld,pc_inc,alu_add,acc_ld,pc_ld}
    function automatic logic [7:0] expect_vec(int p, logic r, logic rdy);
        if (r) return 8'h00;
        case (p)
            PH_ADDR: return 8'b1100_0000;
            PH_WORD: return rdy ? 8'b0011_1000 : 8'b0010_0000;
            PH_ADD:  return 8'b0000_0110;
            PH_LOAD: return 8'b0010_0010;
            PH_TAKE: return 8'b0000_0001;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int p, logic r, logic rdy, logic [2:0] op);
        if (r) return (p == PH_WORD && rdy) ? "R10" : "R1";
        case (p)
            PH_ADDR: return "R2";
            PH_WORD: return rdy ? "R4" : "R3";
            PH_DEC: begin
                if (op == 3'd0) return "R5,R4";
                if (op == 3'd1) return "R6,R4";
                if (op == 3'd2) return "R7,R4";
                return "R8,R4";
            end
            PH_ADD:  return "R5,R9";
            PH_LOAD: return "R6,R9";
            default: return "R7";
        endcase
    endfunction

    // One clock: drive at negedge, compare mid-low phase, advance model at posedge
    task automatic step(input logic r, input logic [2:0] op, input logic z, input logic rdy);
        logic [7:0] got;
        logic [7:0] exp_v;
        string      tg;
        @(negedge clk);
        rst = r; opcode = op; zero_flag = z; mem_rdy = rdy;
        #2;
        got   = {pc_oe, mar_ld, mem_rd, ir_ld, pc_inc, alu_add, acc_ld, pc_ld};
        exp_v = expect_vec(ph, r, rdy);
        tg    = tag_of(ph, r, rdy, op);
        checks++;
        if (got !== exp_v) begin
            failures++;
            $display("FAIL %s phase=%0d actual=%b expected=%b", tg, ph, got, exp_v);
        end
        @(posedge clk);
        if (r) begin
            ph = PH_ADDR;
        end else begin
            case (ph)
                PH_ADDR: ph = PH_WORD;
                PH_WORD: ph = rdy ? PH_DEC : PH_WORD;
                PH_DEC:  ph = (op == 3'd0) ? PH_ADD : (op == 3'd1) ? PH_LOAD :
                              (op == 3'd2) ? PH_BRZ : PH_ADDR;
                PH_BRZ:  ph = z ? PH_TAKE : PH_ADDR;
                default: ph = PH_ADDR;
            endcase
        end
    endtask

    // One instruction; opcode and zero are scrambled where they must be ignored (R9)
    task automatic run_instr(input logic [2:0] op, input logic z, input int waits);
        step(1'b0, ~op, ~z, 1'b0);                                   // address phase
        for (int i = 0; i < waits; i++) step(1'b0, op + 3'd3, ~z, 1'b0); // R3 wait
        step(1'b0, ~op, ~z, 1'b1);                                   // R4 capture
        step(1'b0, op, ~z, 1'b0);                                    // decode
        for (int i = 0; i < 3 && ph != PH_ADDR; i++) begin
            step(1'b0, ~op, (ph == PH_BRZ) ? z : ~z, 1'b1);
        end
    endtask

    initial begin
        // R1: reset cycles, with ready toggling
        step(1'b1, 3'd0, 1'b0, 1'b0);
        step(1'b1, 3'd5, 1'b1, 1'b1);
        step(1'b1, 3'd2, 1'b0, 1'b0);
        // R5: add, ready at once and after waits
        run_instr(3'd0, 1'b0, 0);
        run_instr(3'd0, 1'b1, 3);
        // R6: load
        run_instr(3'd1, 1'b0, 1);
        run_instr(3'd1, 1'b1, 0);
        // R7: branch taken and not taken
        run_instr(3'd2, 1'b1, 0);
        run_instr(3'd2, 1'b0, 2);
        run_instr(3'd2, 1'b1, 5);
        // R8: every no-op code
        for (int c = 3; c < 8; c++) run_instr(3'(c), 1'b1, c - 3);
        // R10: reset lands with memory ready in the word fetch
        step(1'b0, 3'd0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0);
        step(1'b1, 3'd0, 1'b0, 1'b1);
        run_instr(3'd0, 1'b0, 0);
        // R1: reset in the middle of an add
        step(1'b0, 3'd0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b1);
        step(1'b0, 3'd0, 1'b0, 1'b0);
        step(1'b1, 3'd1, 1'b0, 1'b0);
        run_instr(3'd2, 1'b1, 1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule